// File: doc/BRIEF.md
# Indexed Bank-Switch Register File

This block is the processor-facing banking core of a cartridge controller. It watches processor writes in the upper half of the address space. It sorts each write into one of three targets: a command register, an indexed data port, or a nametable mirroring register. Behind the data port sit eleven 8-bit bank registers. The command register's low nibble chooses which bank register a data-port write fills.

From the bank registers and one layout bit of the command register, the block produces bank numbers for eight 1 KB character windows and four 8 KB program windows. It also produces a one-bit mirroring select. The memories that these numbers address are outside the block. The outputs follow the stored state directly, so a write becomes visible on the cycle after the clock edge that captures it.

Top module: `bsw_bank_core`

## Requirements
- R1: In the cycle after a reset, every bank register reads 0xFF, the command register is 0 and the stored mirroring bit is 0. The outputs are therefore character windows 0..7 = FE,FF,FE,FF,FF,FF,FF,FF, all program windows = FF, and `mirror_sel` = 1.
- R2: A write with `wr_en` high is routed by `addr & 0xF001`. The value 0x8000 selects the command register, 0x8001 the data port and 0xA000 the mirroring register. For example, 0x8FFE addresses the command register and 0x8F01 the data port.
- R3: A data-port write stores `wdata` into bank register k, where k is the command register's low nibble, when k is 0 to 9.
- R4: A data-port write with command low nibble 15 stores `wdata` into bank register 10.
- R5: A data-port write with command low nibble 10 to 14 changes no output.
- R6: With command bit 5 set, character windows 0, 1, 2 and 3 (0x0000, 0x0400, 0x0800, 0x0C00) show bank registers 0, 8, 1 and 9 in that order.
- R7: With command bit 5 clear, windows 0 and 1 show bank register 0 with bit 0 forced to 0 and to 1. Windows 2 and 3 do the same with bank register 1.
- R8: Character windows 4 to 7 (0x1000 to 0x1C00) show bank registers 2, 3, 4 and 5.
- R9: Program windows 0, 1 and 2 (0x8000, 0xA000, 0xC000) show bank registers 6, 7 and 10. Program window 3 (0xE000) is always all ones.
- R10: A mirroring-register write keeps `wdata` bit 0, and `mirror_sel` is the inverse of the kept bit.
- R11: A write whose masked address matches none of the three targets, or any cycle with `wr_en` low, leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe, one write per cycle |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| chr_bank | output | 64 | Eight 1 KB character bank numbers, window i in bits [8i+7:8i] |
| prg_bank | output | 32 | Four 8 KB program bank numbers, window i in bits [8i+7:8i] |
| mirror_sel | output | 1 | Mirroring select, the inverse of the stored bit |

## Verification
The bench first fills indices 0 to 9 with distinct values while the layout bit is clear, so any swapped register or lost bit-0 forcing shows up in a specific window. It then sets the layout bit and expects the 0,8,1,9 order. Index 15 is written with the layout bit both clear and set, to separate the remap from a direct index. The reserved indices 10 to 14 are written with a marker value, which exposes any stray store. Aliased addresses and near-miss addresses (0x9000, 0xC000, 0xE001, a low address, and a strobe-low write) separate the masked decode from a full-address or unmasked one.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CMD  = 2'd1,
    TGT_DATA = 2'd2,
    TGT_MIRR = 2'd3
  } bsw_tgt_e;

  localparam logic [15:0] DEC_MASK  = 16'hF001;
  localparam logic [15:0] ADDR_CMD  = 16'h8000;
  localparam logic [15:0] ADDR_DATA = 16'h8001;
  localparam logic [15:0] ADDR_MIRR = 16'hA000;

  localparam int IDX_W      = 4;
  localparam int IDX_REMAP  = 15;

  // Source register for a low character window in split (1 KB) layout
  function automatic int split_src(input int win);
    case (win)
      0:       split_src = 0;
      1:       split_src = 8;
      2:       split_src = 1;
      default: split_src = 9;
    endcase
  endfunction

endpackage

// File: rtl/bsw_decode.sv
module bsw_decode
  import bsw_pkg::*;
(
  input  logic        wr_en,
  input  logic [15:0] addr,
  output bsw_tgt_e    tgt
);

  logic [15:0] masked;
  assign masked = addr & DEC_MASK;

  always_comb begin
    tgt = TGT_NONE;
    if (wr_en) begin
      if (masked == ADDR_CMD)       tgt = TGT_CMD;
      else if (masked == ADDR_DATA) tgt = TGT_DATA;
      else if (masked == ADDR_MIRR) tgt = TGT_MIRR;
    end
  end

endmodule

// File: rtl/bsw_regfile.sv
module bsw_regfile
  import bsw_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               data_we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_flat
);

  localparam int DIRECT_CNT = NREG - 1;
  localparam int HI_SLOT    = NREG - 1;

  logic [DW-1:0] bank_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic hit;
      if (g < DIRECT_CNT) begin : g_direct
        assign hit = data_we && (int'(idx) == g);
      end else begin : g_remap
        assign hit = data_we && (int'(idx) == IDX_REMAP);
      end

      always_ff @(posedge clk) begin
        if (rst)      bank_q[g] <= '1;
        else if (hit) bank_q[g] <= wdata;
      end

      assign regs_flat[g*DW +: DW] = bank_q[g];
    end
  endgenerate

  // Reserved indices must leave the whole file untouched
  AST_RESERVED_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (data_we && int'(idx) >= DIRECT_CNT && int'(idx) != IDX_REMAP) |=> $stable(regs_flat)); // R5

  AST_REMAP_LANDS: assert property (@(posedge clk) disable iff (rst)
    (data_we && int'(idx) == IDX_REMAP) |=> regs_flat[HI_SLOT*DW +: DW] == $past(wdata)); // R4

endmodule

// File: rtl/bsw_window_map.sv
module bsw_window_map
  import bsw_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 11,
  parameter int NCHR = 8,
  parameter int NPRG = 4
) (
  input  logic [NREG*DW-1:0] regs_flat,
  input  logic               split_lo,
  output logic [NCHR*DW-1:0] chr_flat,
  output logic [NPRG*DW-1:0] prg_flat
);

  localparam int LO_WINS  = NCHR / 2;
  localparam int HI_BASE  = 2;
  localparam int PRG_BASE = HI_BASE + LO_WINS;

  function automatic int prg_src(input int win);
    prg_src = (win == 2) ? NREG - 1 : PRG_BASE + win;
  endfunction

  genvar i;
  generate
    for (i = 0; i < NCHR; i++) begin : g_chr
      if (i < LO_WINS) begin : g_lo
        logic [DW-1:0] pair_v;
        assign pair_v = regs_flat[(i/2)*DW +: DW];
        assign chr_flat[i*DW +: DW] = split_lo
          ? regs_flat[split_src(i)*DW +: DW]
          : {pair_v[DW-1:1], 1'(i % 2)};
      end else begin : g_hi
        assign chr_flat[i*DW +: DW] = regs_flat[(HI_BASE + i - LO_WINS)*DW +: DW];
      end
    end

    for (i = 0; i < NPRG; i++) begin : g_prg
      if (i == NPRG - 1) begin : g_fixed
        assign prg_flat[i*DW +: DW] = '1;
      end else begin : g_sel
        assign prg_flat[i*DW +: DW] = regs_flat[prg_src(i)*DW +: DW];
      end
    end
  endgenerate

endmodule

// File: rtl/bsw_bank_core.sv
module bsw_bank_core
  import bsw_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 11,
  parameter int NCHR = 8,
  parameter int NPRG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [15:0]        addr,
  input  logic [7:0]         wdata,
  output logic [NCHR*DW-1:0] chr_bank,
  output logic [NPRG*DW-1:0] prg_bank,
  output logic               mirror_sel
);

  localparam int SPLIT_BIT = 5;

  bsw_tgt_e          tgt;
  logic [IDX_W-1:0]  cmd_idx_q;
  logic              split_q;
  logic              mirr_q;
  logic [NREG*DW-1:0] regs_flat;

  bsw_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .tgt   (tgt)
  );

  // Only the index nibble and the layout bit of the command byte matter
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_idx_q <= '0;
      split_q   <= 1'b0;
      mirr_q    <= 1'b0;
    end else begin
      if (tgt == TGT_CMD) begin
        cmd_idx_q <= wdata[IDX_W-1:0];
        split_q   <= wdata[SPLIT_BIT];
      end
      if (tgt == TGT_MIRR) mirr_q <= wdata[0];
    end
  end

  bsw_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .data_we   (tgt == TGT_DATA),
    .idx       (cmd_idx_q),
    .wdata     (wdata),
    .regs_flat (regs_flat)
  );

  bsw_window_map #(.DW(DW), .NREG(NREG), .NCHR(NCHR), .NPRG(NPRG)) u_map (
    .regs_flat (regs_flat),
    .split_lo  (split_q),
    .chr_flat  (chr_bank),
    .prg_flat  (prg_bank)
  );

  assign mirror_sel = ~mirr_q;

  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ((addr & DEC_MASK) == ADDR_CMD && wr_en) |=>
      (cmd_idx_q == $past(wdata[IDX_W-1:0]) && split_q == $past(wdata[SPLIT_BIT]))); // R2

  AST_MIRROR_INVERTS: assert property (@(posedge clk) disable iff (rst)
    ((addr & DEC_MASK) == ADDR_MIRR && wr_en) |=> mirror_sel == !$past(wdata[0])); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(chr_bank) && $stable(prg_bank) && $stable(mirror_sel))); // R11

  AST_TOP_PRG_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tgt == TGT_DATA) |=> prg_bank[(NPRG-1)*DW +: DW] == '1); // R9

endmodule

// File: tb/bsw_bank_core_tb.sv
module bsw_bank_core_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [63:0] chr_bank;
  logic [31:0] prg_bank;
  logic        mirror_sel;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_reg [11];
  logic [7:0] m_cmd;
  logic       m_mir;

  always #5 clk = ~clk;

  bsw_bank_core u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .chr_bank(chr_bank), .prg_bank(prg_bank), .mirror_sel(mirror_sel)
  );

  function automatic logic [7:0] exp_chr(input int w);
    if (w >= 4) return m_reg[w - 2];
    if (m_cmd[5]) begin
      case (w)
        0: return m_reg[0];
        1: return m_reg[8];
        2: return m_reg[1];
        default: return m_reg[9];
      endcase
    end
    return {m_reg[w / 2][7:1], 1'(w % 2)};
  endfunction

  function automatic logic [7:0] exp_prg(input int w);
    case (w)
      0: return m_reg[6];
      1: return m_reg[7];
      2: return m_reg[10];
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int w = 0; w < 8; w++) begin
      n_cmp++;
      if (chr_bank[w*8 +: 8] !== exp_chr(w)) begin
        n_bad++;
        $display("FAIL %s chr window %0d: got %02h expected %02h", req, w, chr_bank[w*8 +: 8], exp_chr(w));
      end
    end
    for (int w = 0; w < 4; w++) begin
      n_cmp++;
      if (prg_bank[w*8 +: 8] !== exp_prg(w)) begin
        n_bad++;
        $display("FAIL %s prg window %0d: got %02h expected %02h", req, w, prg_bank[w*8 +: 8], exp_prg(w));
      end
    end
    n_cmp++;
    if (mirror_sel !== ~m_mir) begin
      n_bad++;
      $display("FAIL %s mirror_sel: got %0b expected %0b", req, mirror_sel, ~m_mir);
    end
  endtask

  // One write cycle; the reference model updates from the requirements
  task automatic wr(input logic en, input logic [15:0] a, input logic [7:0] d);
    logic [15:0] mk;
    @(negedge clk);
    wr_en = en; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    mk = a & 16'hF001;
    if (en) begin
      if (mk == 16'h8000) m_cmd = d;
      else if (mk == 16'hA000) m_mir = d[0];
      else if (mk == 16'h8001) begin
        if (m_cmd[3:0] < 4'd10) m_reg[m_cmd[3:0]] = d;
        else if (m_cmd[3:0] == 4'hF) m_reg[10] = d;
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 11; k++) m_reg[k] = 8'hFF;
    m_cmd = 8'h00; m_mir = 1'b0;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_fill_paired;
    for (int k = 0; k < 10; k++) begin
      wr(1'b1, 16'h8000, 8'(k));
      wr(1'b1, 16'h8001, 8'(8'h31 + 8'(k * 17)));
      check_all("R3");
    end
    check_all("R7");
    check_all("R8");
    check_all("R9");
  endtask

  task automatic t_split;
    wr(1'b1, 16'h8000, 8'h20);
    check_all("R6");
    wr(1'b1, 16'h8000, 8'h28);
    wr(1'b1, 16'h8001, 8'h5A);
    check_all("R6");
    wr(1'b1, 16'h8000, 8'hC0);
    check_all("R7");
  endtask

  task automatic t_remap;
    wr(1'b1, 16'h8000, 8'h0F);
    wr(1'b1, 16'h8001, 8'h3C);
    check_all("R4");
    wr(1'b1, 16'h8000, 8'h2F);
    wr(1'b1, 16'h8001, 8'hC3);
    check_all("R4");
  endtask

  task automatic t_reserved;
    for (int k = 10; k < 15; k++) begin
      wr(1'b1, 16'h8000, 8'(k));
      wr(1'b1, 16'h8001, 8'hAA);
      check_all("R5");
    end
  endtask

  task automatic t_mirror;
    wr(1'b1, 16'hA000, 8'h01);
    check_all("R10");
    wr(1'b1, 16'hAFFE, 8'hFE);
    check_all("R10");
    wr(1'b1, 16'hA000, 8'h03);
    check_all("R10");
  endtask

  task automatic t_decode;
    wr(1'b1, 16'h8FFE, 8'h03);
    wr(1'b1, 16'h8F01, 8'h77);
    check_all("R2");
    wr(1'b1, 16'h9000, 8'h05);
    wr(1'b1, 16'h9001, 8'h11);
    check_all("R11");
    wr(1'b1, 16'hC000, 8'h22);
    wr(1'b1, 16'hC001, 8'h23);
    wr(1'b1, 16'hE000, 8'h24);
    wr(1'b1, 16'hE001, 8'h25);
    wr(1'b1, 16'h0001, 8'h26);
    wr(1'b1, 16'hA001, 8'h00);
    check_all("R11");
    wr(1'b0, 16'h8001, 8'h99);
    wr(1'b0, 16'hA000, 8'h00);
    check_all("R11");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_paired();
    t_split();
    t_remap();
    t_reserved();
    t_mirror();
    t_decode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule